// File: doc/BRIEF.md
# Multilevel Space-Vector Switching State Selector

This block serves the modulator of a three-phase inverter with a configurable number of voltage levels. It is given the three corner points of the lattice triangle that surrounds the reference vector. Each point is a pair of signed integer coordinates on two oblique axes that lie 60 degrees apart. From these points it returns one switching function per corner. A switching function is a triple of leg levels, one for each phase leg, and each level runs from 0 to LEVELS-1.

When a corner can be produced by more than one switching state, the block picks one with closed-form arithmetic and no table. It first finds the hexagon ring of each corner and takes the largest ring as the triangle level k. It then places the triangle in one of three 120-degree sectors. Within a sector, one leg is held at level k for every corner. That leg therefore does not switch while the three corners are applied in turn.

The block has one register stage. A triangle presented with `inValid` high appears on the outputs after the next rising clock edge. The outputs keep their values until a new triangle is accepted. The selector does not transform phase voltages into the oblique frame, search for the triangle, compute duty ratios or balance the DC bus.

Top module: `mlsv_state_sel`

## Requirements
- R1: `outValid` equals the value that `inValid` had at the previous rising clock edge. Results for a triangle accepted at edge n appear on the outputs just after edge n.
- R2: While `inValid` is low, `outSector`, `outLevel` and `outLegs` keep their previous values.
- R3: While `rstN` is low, `outValid`, `outSector`, `outLevel` and `outLegs` are all zero.
- R4: The ring of a corner (g,h) is max(|g|,|h|,|g+h|). The triangle level k is the largest ring among the three corners. `outLevel` reports k, limited to LEVELS-1.
- R5: The sector is decided on the coordinate sums G=g0+g1+g2 and H=h0+h1+h2, in this order of priority:
  - code 0 (sector A) if G>0 and G+H>0;
  - code 1 (sector B) if G<0 and H>0;
  - code 2 (sector C) if H<0 and G+H<0;
  - code 0 if none of the three tests holds.
- R6: In sector A, the legs of a corner are a=k, b=|k-|g||, c=|k-|g|-|h||.
- R7: In sector B, the legs of a corner are a=|k-|g||, b=k, c=|k-|h||.
- R8: In sector C, the legs of a corner are a=|k-|g|-|h||, b=|k-|h||, c=k.
- R9: Every leg level is limited to LEVELS-1. A formula result above that value is output as LEVELS-1.
- R10: The leg that is held in the reported sector equals `outLevel` for all three corners. That leg is a in sector A, b in sector B and c in sector C.

Field layout: corner v occupies bits [v*COORD_W +: COORD_W] of `inG` and `inH`. Leg p of corner v, with p=0,1,2 for legs a, b, c, occupies bits [(3*v+p)*LEG_W +: LEG_W] of `outLegs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A new triangle is present on `inG` and `inH` |
| inG | input | 3*COORD_W | Signed g coordinate of each of the three corners |
| inH | input | 3*COORD_W | Signed h coordinate of each of the three corners |
| outValid | output | 1 | The outputs hold a result accepted at the last edge |
| outSector | output | 2 | Sector code: 0 for A, 1 for B, 2 for C |
| outLevel | output | LEG_W | Triangle level k, limited to LEVELS-1 |
| outLegs | output | 9*LEG_W | Leg levels of the three corners |

## Verification
The assertions assume only that the inputs are two's-complement numbers of COORD_W bits. They do not assume that the three corners form a real adjacent triangle or that the corners lie inside the modulation hexagon. For this reason the range and clamping properties are written against the limited values.

The stimulus contains real triangles in every sector and on the sector boundaries. It also sweeps every coordinate, including the most negative code, so that rings larger than LEVELS-1 exercise the limiting. Pauses with `inValid` low are mixed into the stream to exercise the hold behaviour.

// File: rtl/mlsv_pkg.sv
package mlsv_pkg;
  typedef enum logic [1:0] {
    SEC_A = 2'd0,
    SEC_B = 2'd1,
    SEC_C = 2'd2
  } sector_e;

  typedef struct packed {
    logic load;
    logic validQ;
  } ctrl_s;
endpackage

// File: rtl/mlsv_ctrl.sv
module mlsv_ctrl
  import mlsv_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  inValid,
  output ctrl_s ctrl
);
  logic validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= inValid;
  end

  always_comb begin
    ctrl.load   = inValid;
    ctrl.validQ = validQ;
  end

  // R1
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> validQ);
endmodule

// File: rtl/mlsv_datapath.sv
module mlsv_datapath
  import mlsv_pkg::*;
#(
  parameter int LEVELS  = 3,
  parameter int COORD_W = 3,
  parameter int LEG_W   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_s                ctrl,
  input  logic [3*COORD_W-1:0] inG,
  input  logic [3*COORD_W-1:0] inH,
  output sector_e              sectorQ,
  output logic [LEG_W-1:0]     levelQ,
  output logic [9*LEG_W-1:0]   legsQ
);
  localparam int CW = COORD_W + 3;
  localparam logic signed [CW-1:0] MAXL = CW'(LEVELS - 1);

  logic signed [CW-1:0] gv [3];
  logic signed [CW-1:0] hv [3];
  logic signed [CW-1:0] absG [3];
  logic signed [CW-1:0] absH [3];
  logic signed [CW-1:0] ring [3];
  logic signed [CW-1:0] kW;
  logic signed [CW-1:0] sumG, sumH, sumGH;
  sector_e              sectorNext;
  logic [LEG_W-1:0]     levelNext;
  logic [9*LEG_W-1:0]   legsNext;

  function automatic logic signed [CW-1:0] absV(input logic signed [CW-1:0] x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic logic [LEG_W-1:0] satV(input logic signed [CW-1:0] x);
    return (x > MAXL) ? MAXL[LEG_W-1:0] : x[LEG_W-1:0];
  endfunction

  for (genvar v = 0; v < 3; v++) begin : g_ring
    logic signed [CW-1:0] absS;
    always_comb begin
      gv[v]   = CW'(signed'(inG[v*COORD_W +: COORD_W]));
      hv[v]   = CW'(signed'(inH[v*COORD_W +: COORD_W]));
      absG[v] = absV(gv[v]);
      absH[v] = absV(hv[v]);
      absS    = absV(gv[v] + hv[v]);
      ring[v] = absG[v];
      if (absH[v] > ring[v]) ring[v] = absH[v];
      if (absS > ring[v])    ring[v] = absS;
    end
  end

  always_comb begin
    kW = ring[0];
    if (ring[1] > kW) kW = ring[1];
    if (ring[2] > kW) kW = ring[2];
    levelNext = satV(kW);

    sumG  = gv[0] + gv[1] + gv[2];
    sumH  = hv[0] + hv[1] + hv[2];
    sumGH = sumG + sumH;
    if (sumG > 0 && sumGH > 0)      sectorNext = SEC_A;
    else if (sumG < 0 && sumH > 0)  sectorNext = SEC_B;
    else if (sumH < 0 && sumGH < 0) sectorNext = SEC_C;
    else                            sectorNext = SEC_A;
  end

  for (genvar v = 0; v < 3; v++) begin : g_legs
    logic signed [CW-1:0] offG, offGH, offH;
    logic signed [CW-1:0] legA, legB, legC;
    always_comb begin
      offG  = absV(kW - absG[v]);
      offGH = absV(kW - absG[v] - absH[v]);
      offH  = absV(kW - absH[v]);
      case (sectorNext)
        SEC_B:   begin legA = offG;  legB = kW;   legC = offH; end
        SEC_C:   begin legA = offGH; legB = offH; legC = kW;   end
        default: begin legA = kW;    legB = offG; legC = offGH; end
      endcase
      legsNext[(3*v+0)*LEG_W +: LEG_W] = satV(legA);
      legsNext[(3*v+1)*LEG_W +: LEG_W] = satV(legB);
      legsNext[(3*v+2)*LEG_W +: LEG_W] = satV(legC);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sectorQ <= SEC_A;
      levelQ  <= '0;
      legsQ   <= '0;
    end else if (ctrl.load) begin
      sectorQ <= sectorNext;
      levelQ  <= levelNext;
      legsQ   <= legsNext;
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> ($stable(legsQ) && $stable(levelQ) && $stable(sectorQ)));

  // R5
  sector_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    sectorQ != 2'd3);

  for (genvar i = 0; i < 9; i++) begin : g_rangeChk
    // R9
    leg_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      legsQ[i*LEG_W +: LEG_W] <= MAXL[LEG_W-1:0]);
  end

  for (genvar v = 0; v < 3; v++) begin : g_clampChk
    // R10
    clamp_leg_chk: assert property (@(posedge clk) disable iff (!rstN)
      legsQ[(3*v + int'(sectorQ))*LEG_W +: LEG_W] == levelQ);
  end
endmodule

// File: rtl/mlsv_state_sel.sv
module mlsv_state_sel
  import mlsv_pkg::*;
#(
  parameter int LEVELS  = 3,
  parameter int COORD_W = $clog2(LEVELS) + 1,
  parameter int LEG_W   = (LEVELS > 2) ? $clog2(LEVELS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [3*COORD_W-1:0] inG,
  input  logic [3*COORD_W-1:0] inH,
  output logic                 outValid,
  output logic [1:0]           outSector,
  output logic [LEG_W-1:0]     outLevel,
  output logic [9*LEG_W-1:0]   outLegs
);
  ctrl_s   ctrl;
  sector_e sectorQ;

  mlsv_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .ctrl    (ctrl)
  );

  mlsv_datapath #(
    .LEVELS  (LEVELS),
    .COORD_W (COORD_W),
    .LEG_W   (LEG_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .inG     (inG),
    .inH     (inH),
    .sectorQ (sectorQ),
    .levelQ  (outLevel),
    .legsQ   (outLegs)
  );

  assign outValid  = ctrl.validQ;
  assign outSector = sectorQ;
endmodule

// File: tb/mlsv_state_sel_tb_top.sv
`timescale 1ns/1ps
module mlsv_state_sel_tb_top;
  localparam int LEVELS  = 3;
  localparam int COORD_W = 3;
  localparam int LEG_W   = 2;
  localparam int MAXL    = LEVELS - 1;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 inValid = 1'b0;
  logic [3*COORD_W-1:0] inG = '0;
  logic [3*COORD_W-1:0] inH = '0;
  logic                 outValid;
  logic [1:0]           outSector;
  logic [LEG_W-1:0]     outLevel;
  logic [9*LEG_W-1:0]   outLegs;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  int mValid, mSector, mLevel, mSat, mFresh;
  int mLegs [9];

  always #4 clk = ~clk;

  mlsv_state_sel #(.LEVELS(LEVELS), .COORD_W(COORD_W), .LEG_W(LEG_W)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inG(inG), .inH(inH),
    .outValid(outValid), .outSector(outSector), .outLevel(outLevel), .outLegs(outLegs)
  );

  function automatic int iabs(int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic int lim(int x);
    return (x > MAXL) ? MAXL : x;
  endfunction

  task automatic check(string tag, int got, int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference: recompute from the requirements at each accepting edge.
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mValid = 0; mSector = 0; mLevel = 0; mSat = 0; mFresh = 0;
      foreach (mLegs[i]) mLegs[i] = 0;
    end else begin
      mValid = inValid;
      mFresh = inValid;
      if (inValid) begin
        int g[3], h[3], rg[3];
        int k, sg, sh, a, b, c;
        k = 0; sg = 0; sh = 0; mSat = 0;
        for (int v = 0; v < 3; v++) begin
          g[v] = int'(signed'(inG[v*COORD_W +: COORD_W]));
          h[v] = int'(signed'(inH[v*COORD_W +: COORD_W]));
          rg[v] = iabs(g[v]);
          if (iabs(h[v]) > rg[v]) rg[v] = iabs(h[v]);
          if (iabs(g[v] + h[v]) > rg[v]) rg[v] = iabs(g[v] + h[v]);
          if (rg[v] > k) k = rg[v];
          sg += g[v]; sh += h[v];
        end
        if (sg > 0 && sg + sh > 0)      mSector = 0;
        else if (sg < 0 && sh > 0)      mSector = 1;
        else if (sh < 0 && sg + sh < 0) mSector = 2;
        else                            mSector = 0;
        mLevel = lim(k);
        for (int v = 0; v < 3; v++) begin
          case (mSector)
            0: begin a = k; b = iabs(k - iabs(g[v])); c = iabs(k - iabs(g[v]) - iabs(h[v])); end
            1: begin a = iabs(k - iabs(g[v])); b = k; c = iabs(k - iabs(h[v])); end
            default: begin a = iabs(k - iabs(g[v]) - iabs(h[v])); b = iabs(k - iabs(h[v])); c = k; end
          endcase
          if (a > MAXL || b > MAXL || c > MAXL) mSat = 1;
          mLegs[3*v+0] = lim(a);
          mLegs[3*v+1] = lim(b);
          mLegs[3*v+2] = lim(c);
        end
      end
    end
  end

  // Compare every cycle, away from the rising edge.
  always @(negedge clk) begin
    string legTag;
    cycles++;
    if (!rstN) begin
      check("R3 outValid", int'(outValid), 0);
      check("R3 outSector", int'(outSector), 0);
      check("R3 outLevel", int'(outLevel), 0);
      check("R3 outLegs", int'(outLegs != 0), 0);
    end else begin
      check("R1 outValid", int'(outValid), mValid);
      if (!mFresh) legTag = "R2 held";
      else if (mSat) legTag = "R9 limit";
      else if (mSector == 0) legTag = "R6 sectorA";
      else if (mSector == 1) legTag = "R7 sectorB";
      else legTag = "R8 sectorC";
      check(mFresh ? "R5 sector" : "R2 sector", int'(outSector), mSector);
      check(mFresh ? "R4 level" : "R2 level", int'(outLevel), mLevel);
      for (int i = 0; i < 9; i++)
        check($sformatf("%s leg%0d", legTag, i), int'(outLegs[i*LEG_W +: LEG_W]), mLegs[i]);
      for (int v = 0; v < 3; v++)
        check("R10 clamp", int'(outLegs[(3*v + int'(outSector))*LEG_W +: LEG_W]), int'(outLevel));
    end
  end

  task automatic send(input int g0, h0, g1, h1, g2, h2, input bit vld);
    @(negedge clk); #1;
    inValid = vld;
    inG = {COORD_W'(g2), COORD_W'(g1), COORD_W'(g0)};
    inH = {COORD_W'(h2), COORD_W'(h1), COORD_W'(h0)};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    // R6 sector A triangle
    send(1, 0, 2, 0, 1, 1, 1);
    // R7 sector B triangle
    send(-1, 1, -1, 2, 0, 1, 1);
    // R8 sector C triangle
    send(0, -1, 1, -2, 0, -2, 1);
    // R2 pause with garbage inputs
    send(-3, 2, 1, 1, 0, -4, 0);
    send(2, -2, 2, -1, 1, -1, 0);
    // R5 origin triangles and priority default
    send(0, 0, 1, 0, 0, 1, 1);
    send(0, 0, -1, 0, 0, -1, 1);
    send(0, 0, 0, 0, 0, 0, 1);
    send(0, 0, 1, 0, -1, 1, 1);
    // R9 ring beyond LEVELS-1
    send(3, 0, 3, 0, 3, 0, 1);
    send(-4, -4, -4, 3, 3, -4, 1);
    // sweep of all coordinate codes with pauses
    for (int i = 0; i < 600; i++) begin
      send($urandom_range(7) - 4, $urandom_range(7) - 4,
           $urandom_range(7) - 4, $urandom_range(7) - 4,
           $urandom_range(7) - 4, $urandom_range(7) - 4,
           ($urandom_range(3) != 0));
    end
    send(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R3 reset in mid-stream
    #1 rstN = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    nFails++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", cycles, 20000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule